// File: doc/BRIEF.md
# Quarter-Phase High-Resolution PWM Generator

This block produces one pulse-width-modulated gate signal whose falling edge can be placed to a quarter of the system clock period. Each clock cycle is split into four equal slots. Every cycle the block presents a 4-bit slot vector. A downstream phase serializer, or a set of phase-shifted output registers, turns that vector into the pin waveform. At a 50 MHz clock this gives 5 ns edge placement. A 100 kHz switching period is then 2000 quarter steps, where a whole-clock compare would give only 500 steps (0.2 % granularity).

Software or a control loop supplies a duty count and a period count, both in quarter-clock units, together with a load strobe. Both values go into shadow registers. They become active only when a new period starts, so a change never splits a pulse. An external synchronisation pulse restarts the period so that several converters can stay phase-aligned. An enable input forces the output low and parks the counter. Every pin is a plain control or data level: no data stream flows through the block, so there is no valid/ready pair and no back-pressure. A load strobe is always accepted in the cycle it is asserted.

Top module: `qpwm_gen`

## Requirements
- R1: While `rst_n` is low, and after it is released until the first load, the slot vector is 0000 and the shadow and active duty and period values are zero.
- R2: When enabled and with no sync, the clock index advances by one per cycle and wraps to 0 after max(P>>2, 1) cycles, where P is the active period count. The two low bits of the period count are ignored.
- R3: When enabled, slot bit i (bit 0 is the earliest slot of the cycle) is 1 exactly when 4*k+i < D. Here k is the clock index within the period and D is the active duty count. Within a cycle the pattern is therefore a run of ones starting at bit 0.
- R4: An active duty of 0 keeps every slot low for the whole period. An active duty of at least 4*max(P>>2,1) keeps every slot high for the whole period.
- R5: `load_i` high at a clock edge copies `duty_i` into the duty shadow. The active duty takes the shadow value only at a period start (wrap, sync or enable low). A load at the same edge as a period start waits for the next period start.
- R6: The period count is double-buffered under the same `load_i` strobe and the same rule as R5.
- R7: `sync_i` high at an enabled edge sets the clock index to 0 and reloads both active values from the shadows. Sync has priority over the normal wrap and the normal advance.
- R8: While `en_i` is low the slot vector is 0000 in the same cycle, the clock index is held at 0, and the active values follow the shadows. The first enabled cycle therefore starts a fresh period with the latest loaded values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Output enable; low parks the counter and blanks the output |
| sync_i | input | 1 | External period restart pulse |
| load_i | input | 1 | Capture `duty_i` and `period_i` into the shadows |
| duty_i | input | 11 | Duty count in quarter-clock units |
| period_i | input | 11 | Period count in quarter-clock units (low two bits ignored) |
| slots_o | output | 4 | Quarter-slot levels for this cycle, bit 0 earliest |

## Verification
A load strobe can land on the same edge as a period start, which is either a wrap or a sync. In that case the shadow update and the shadow-to-active transfer happen together, and the old shadow must win. The bench provokes this by driving random loads and sync pulses over short periods, so that coincidences are frequent. A behavioural model that applies the transfer before the capture judges every cycle. Sync arriving on the wrap cycle, and enable falling mid-period, are raised the same way and compared slot by slot.

// File: rtl/qpwm_pkg.sv
package qpwm_pkg;
  localparam int unsigned SLOT_BITS = 2;
  localparam int unsigned NSLOT     = 1 << SLOT_BITS;
  localparam int unsigned DEF_CNT_W = 11;
endpackage

// File: rtl/qpwm_shadow.sv
module qpwm_shadow #(
  parameter int unsigned CNT_W = qpwm_pkg::DEF_CNT_W,
  localparam int unsigned CLK_W = CNT_W - qpwm_pkg::SLOT_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CLK_W-1:0] plen_i,
  input  logic             reload_i,
  output logic [CNT_W-1:0] duty_act_o,
  output logic [CLK_W-1:0] plen_act_o
);
  logic [CNT_W-1:0] duty_sh;
  logic [CLK_W-1:0] plen_sh;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_sh <= '0;
      plen_sh <= '0;
    end else if (load_i) begin
      duty_sh <= duty_i;
      plen_sh <= plen_i;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      duty_act_o <= '0;
      plen_act_o <= '0;
    end else if (reload_i) begin
      duty_act_o <= duty_sh;
      plen_act_o <= plen_sh;
    end
  end

  // R5 / R6: active values only move at a period start
  a_r5_duty_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_i |=> $stable(duty_act_o));
  a_r6_period_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reload_i |=> $stable(plen_act_o));
endmodule

// File: rtl/qpwm_counter.sv
module qpwm_counter #(
  parameter int unsigned CNT_W = qpwm_pkg::DEF_CNT_W,
  localparam int unsigned CLK_W = CNT_W - qpwm_pkg::SLOT_BITS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             sync_i,
  input  logic [CLK_W-1:0] plen_i,
  output logic [CLK_W-1:0] idx_o,
  output logic             reload_o
);
  logic [CLK_W-1:0] last_idx;
  logic             at_last;

  always_comb begin
    if (plen_i == '0) last_idx = '0;
    else              last_idx = plen_i - CLK_W'(1);
  end

  assign at_last  = (idx_o >= last_idx);
  assign reload_o = !en_i || sync_i || at_last;

  always_ff @(posedge clk) begin
    if (!rst_n)        idx_o <= '0;
    else if (reload_o) idx_o <= '0;
    else               idx_o <= idx_o + CLK_W'(1);
  end

  // R8: parked at zero while disabled
  a_r8_park: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> idx_o == '0);
  // R7: sync restarts the period
  a_r7_sync_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && sync_i) |=> idx_o == '0);
  // R2: plain advance by one clock index
  a_r2_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && !sync_i && idx_o < last_idx) |=> idx_o == $past(idx_o) + CLK_W'(1));
endmodule

// File: rtl/qpwm_slot_cmp.sv
module qpwm_slot_cmp #(
  parameter int unsigned CNT_W = qpwm_pkg::DEF_CNT_W,
  localparam int unsigned CLK_W = CNT_W - qpwm_pkg::SLOT_BITS,
  localparam int unsigned NSLOT = qpwm_pkg::NSLOT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [CLK_W-1:0] idx_i,
  input  logic [CNT_W-1:0] duty_i,
  output logic [NSLOT-1:0] slots_o
);
  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    localparam logic [qpwm_pkg::SLOT_BITS-1:0] SL = qpwm_pkg::SLOT_BITS'(s);
    logic [CNT_W-1:0] qidx;
    assign qidx       = {idx_i, SL};
    assign slots_o[s] = en_i && (qidx < duty_i);
  end

  // R3: ones always start at the earliest slot
  a_r3_thermometer: assert property (@(posedge clk) disable iff (!rst_n)
    (slots_o[NSLOT-1:1] & ~slots_o[NSLOT-2:0]) == '0);
  // R4: zero duty never drives a slot
  a_r4_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
    (duty_i == '0) |-> slots_o == '0);
  // R8: disabled output is blank
  a_r8_blank: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |-> slots_o == '0);
endmodule

// File: rtl/qpwm_gen.sv
module qpwm_gen #(
  parameter int unsigned CNT_W = qpwm_pkg::DEF_CNT_W,
  localparam int unsigned CLK_W = CNT_W - qpwm_pkg::SLOT_BITS,
  localparam int unsigned NSLOT = qpwm_pkg::NSLOT
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             sync_i,
  input  logic             load_i,
  input  logic [CNT_W-1:0] duty_i,
  input  logic [CNT_W-1:0] period_i,
  output logic [NSLOT-1:0] slots_o
);
  logic [CLK_W-1:0] plen_act;
  logic [CNT_W-1:0] duty_act;
  logic [CLK_W-1:0] idx;
  logic             reload;
  logic             unused_period_lsb;

  assign unused_period_lsb = ^period_i[qpwm_pkg::SLOT_BITS-1:0];

  qpwm_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (load_i),
    .duty_i     (duty_i),
    .plen_i     (period_i[CNT_W-1:qpwm_pkg::SLOT_BITS]),
    .reload_i   (reload),
    .duty_act_o (duty_act),
    .plen_act_o (plen_act)
  );

  qpwm_counter #(.CNT_W(CNT_W)) u_counter (
    .clk      (clk),
    .rst_n    (rst_n),
    .en_i     (en_i),
    .sync_i   (sync_i),
    .plen_i   (plen_act),
    .idx_o    (idx),
    .reload_o (reload)
  );

  qpwm_slot_cmp #(.CNT_W(CNT_W)) u_cmp (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .idx_i   (idx),
    .duty_i  (duty_act),
    .slots_o (slots_o)
  );

  // R1: blank output in the cycle after reset
  a_r1_reset_blank: assert property (@(posedge clk)
    !rst_n |=> slots_o == '0);
endmodule

// File: tb/qpwm_gen_test.sv
`timescale 1ns/1ps
module qpwm_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en_i = 1'b0;
  logic        sync_i = 1'b0;
  logic        load_i = 1'b0;
  logic [10:0] duty_i = '0;
  logic [10:0] period_i = '0;
  logic [3:0]  slots_o;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;
  bit done   = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_idx = 0, m_dact = 0, m_dsh = 0, m_pact = 0, m_psh = 0;

  qpwm_gen uut (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .sync_i(sync_i),
    .load_i(load_i), .duty_i(duty_i), .period_i(period_i), .slots_o(slots_o)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    int len;
    cycle++;
    if (!rst_n) begin
      m_idx = 0; m_dact = 0; m_dsh = 0; m_pact = 0; m_psh = 0;
    end else begin
      len = m_pact / 4;
      if (len == 0) len = 1;
      if (!en_i || sync_i || m_idx >= len - 1) begin
        m_idx = 0; m_dact = m_dsh; m_pact = m_psh;
      end else begin
        m_idx++;
      end
      if (load_i) begin
        m_dsh = int'(duty_i); m_psh = int'(period_i);
      end
    end
  end

  function automatic logic [3:0] expect_slots();
    logic [3:0] e;
    for (int s = 0; s < 4; s++) e[s] = en_i && (m_idx * 4 + s < m_dact);
    return e;
  endfunction

  always @(negedge clk) begin
    logic [3:0] e;
    if (!done) begin
      e = expect_slots();
      checks++;
      if (slots_o !== e) begin
        errors++;
        $display("FAIL %s: slots=%b expected %b at cycle %0d", cur_req, slots_o, e, cycle);
      end
    end
  end

  task automatic cyc(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      #2;
    end
  endtask

  task automatic load(int d, int p);
    duty_i = 11'(d); period_i = 11'(p); load_i = 1'b1;
    cyc();
    load_i = 1'b0;
  endtask

  initial begin
    cyc(4);
    cur_req = "R1";
    checks++;
    if (slots_o !== 4'b0000) begin
      errors++;
      $display("FAIL R1: slots=%b expected 0000 in reset", slots_o);
    end
    rst_n = 1'b1;
    cyc(5);
    en_i = 1'b1;
    cyc(10);

    cur_req = "R3";
    load(13, 40);
    cyc(45);
    load(18, 40);
    cyc(40);

    cur_req = "R2";
    load(1000, 2000);
    cyc(1100);
    load(21, 42);
    cyc(60);
    load(3, 2);
    cyc(10);

    cur_req = "R4";
    load(0, 40);
    cyc(30);
    load(40, 40);
    cyc(30);
    load(2047, 40);
    cyc(30);
    load(2047, 2047);
    cyc(1100);

    cur_req = "R5";
    for (int i = 0; i < 600; i++) begin
      if ($urandom_range(0, 3) == 0) load($urandom_range(0, 45), 40);
      else cyc();
    end

    cur_req = "R6";
    for (int i = 0; i < 800; i++) begin
      if ($urandom_range(0, 5) == 0) load($urandom_range(0, 60), $urandom_range(0, 60));
      else cyc();
    end

    cur_req = "R7";
    load(17, 24);
    for (int i = 0; i < 1000; i++) begin
      sync_i = ($urandom_range(0, 6) == 0);
      if ($urandom_range(0, 4) == 0) load($urandom_range(0, 30), 24);
      else cyc();
    end
    sync_i = 1'b0;

    cur_req = "R8";
    for (int i = 0; i < 1000; i++) begin
      en_i = ($urandom_range(0, 5) != 0);
      if ($urandom_range(0, 4) == 0) load($urandom_range(0, 40), 32);
      else cyc();
    end
    en_i = 1'b1;

    cur_req = "R5";
    for (int i = 0; i < 2000; i++) begin
      en_i   = ($urandom_range(0, 15) != 0);
      sync_i = ($urandom_range(0, 9) == 0);
      if ($urandom_range(0, 2) == 0) load($urandom_range(0, 70), $urandom_range(0, 64));
      else cyc();
    end
    sync_i = 1'b0;
    cyc(3);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: run did not complete, expected finish before 150000 cycles");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule